// File: doc/BRIEF.md
# Run-Length Sample Compressor

This block watches a parallel probe bus and turns the stream of samples into run-length records. A record pairs a sample value with the number of qualified cycles for which that value was held. While the value stays the same, the block only counts. It emits the finished run as a single registered record when the value changes or when the count cannot grow any further. A capture buffer controller stores the records one per strobe, so slow signals use very little memory.

A qualifier input selects which clock cycles count as samples. Cycles with the qualifier low are neither compared nor counted. A flush request pushes out the run in progress so that the last stretch of a capture is kept. An arm request starts a fresh capture and drops the pending run without writing it. A count of zero never appears in an emitted record, so the buffer can use an all-zero word to mark a slot that holds no data.

Top module: `rle_sample_compressor`

## Requirements
- R1: After reset, `rec_valid` is low, `rec_word` is zero and no run is pending. The first qualified sample starts a run with count 1.
- R2: A qualified sample that differs from the value of the pending run emits that run as a record, with `rec_valid` high in the cycle after the sample. The record word holds the count in bits [CNT_W+VAL_W-1:VAL_W] and the value in bits [VAL_W-1:0]. The differing sample starts a new run with count 1.
- R3: The largest count a record can carry is 2^CNT_W-2, which is 254 for CNT_W=8. A qualified sample equal to a run already at that count emits the saturated record and continues the same value as a new run with count 1. With CNT_W=8, a value held for 300 qualified cycles yields the record {254,v} followed by the record {46,v}.
- R4: A probe that changes on every qualified cycle yields one record per sample, each with count 1, and no sample is lost.
- R5: Cycles with `sample_en` low are neither counted nor compared. A probe change that happens only during such cycles has no effect on the records.
- R6: `flush` with a run pending emits that run in the next cycle and ends it. If `sample_en` is high in the same cycle, that sample starts a new run with count 1.
- R7: `flush` with no run pending produces no record.
- R8: `arm` discards the pending run without emitting a record, and the sample in the arm cycle is ignored. The first qualified sample after arm starts a run with count 1.
- R9: While `rec_valid` is low, `rec_word` is all zeros. Every emitted record has a count between 1 and 2^CNT_W-2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start a new capture and drop the pending run |
| sample_en | input | 1 | Sample qualifier; high cycles are sampled and counted |
| flush | input | 1 | Emit the pending run now |
| probe | input | VAL_W | Probed sample bus |
| rec_valid | output | 1 | Record strobe, high for one cycle per record |
| rec_word | output | CNT_W+VAL_W | Record {count, value}; zero when no record |

## Verification
The hardest case to reach is the saturation boundary. It needs hundreds of unbroken qualified cycles of the same value, and then a continuation record must follow that repeats the value. The stimulus holds one value for exactly 300 qualified cycles and then flushes, so both the saturated record and the remainder record can be compared against 254 and 46. A flush that coincides with a qualified sample is also driven, to show that the run is split without losing that sample.

// File: rtl/rle_pkg.sv
package rle_pkg;

  // Largest count a record may carry; all-ones is left unused and zero marks an empty slot.
  function automatic int unsigned cnt_ceiling(input int unsigned cnt_w);
    return (32'd1 << cnt_w) - 32'd2;
  endfunction

  // Count after one more matching qualified sample.
  function automatic int unsigned cnt_advance(input int unsigned cnt);
    return cnt + 32'd1;
  endfunction

  // Position of the count field inside a record word.
  function automatic int unsigned cnt_lsb(input int unsigned val_w);
    return val_w;
  endfunction

endpackage

// File: rtl/rle_run_counter.sv
module rle_run_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_one,
  input  logic             clear,
  input  logic             bump,
  output logic [CNT_W-1:0] run_cnt,
  output logic             run_live,
  output logic             at_ceiling
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(rle_pkg::cnt_ceiling(CNT_W));

  assign at_ceiling = (run_cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      run_live <= 1'b0;
    end else if (load_one) begin
      run_cnt  <= CNT_W'(1);
      run_live <= 1'b1;
    end else if (clear) begin
      run_cnt  <= '0;
      run_live <= 1'b0;
    end else if (bump) begin
      run_cnt  <= CNT_W'(rle_pkg::cnt_advance(int'(run_cnt)));
    end
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= CNT_MAX);

  // R3
  bump_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && !load_one && !clear) |=> run_cnt == $past(run_cnt) + CNT_W'(1));

  // R9
  live_cnt_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_live == (run_cnt != '0));

endmodule

// File: rtl/rle_change_det.sv
module rle_change_det #(
  parameter int VAL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [VAL_W-1:0] probe,
  output logic [VAL_W-1:0] held_val,
  output logic             differs
);
  always_ff @(posedge clk) begin
    if (!rst_n)       held_val <= '0;
    else if (capture) held_val <= probe;
  end

  assign differs = (probe != held_val);

  // R2
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> held_val == $past(probe));

endmodule

// File: rtl/rle_record_reg.sv
module rle_record_reg #(
  parameter int CNT_W = 8,
  parameter int VAL_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   emit,
  input  logic [CNT_W-1:0]       cnt,
  input  logic [VAL_W-1:0]       val,
  output logic                   rec_valid,
  output logic [CNT_W+VAL_W-1:0] rec_word
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_valid <= 1'b0;
      rec_word  <= '0;
    end else begin
      rec_valid <= emit;
      rec_word  <= emit ? {cnt, val} : '0;
    end
  end

  // R9
  emit_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> cnt != '0);

endmodule

// File: rtl/rle_sample_compressor.sv
module rle_sample_compressor #(
  parameter int CNT_W = 8,
  parameter int VAL_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   arm,
  input  logic                   sample_en,
  input  logic                   flush,
  input  logic [VAL_W-1:0]       probe,
  output logic                   rec_valid,
  output logic [CNT_W+VAL_W-1:0] rec_word
);
  localparam int          REC_W   = CNT_W + VAL_W;
  localparam int          CNT_LSB = rle_pkg::cnt_lsb(VAL_W);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(rle_pkg::cnt_ceiling(CNT_W));

  logic             qual;
  logic             differs;
  logic [VAL_W-1:0] run_val;
  logic [CNT_W-1:0] run_cnt;
  logic             run_live;
  logic             at_ceiling;
  logic             ev_change, ev_sat, ev_flush, emit;
  logic             load_one, clear, bump;

  // Named internal events, also used by the assertions below.
  assign qual      = sample_en && !arm;
  assign ev_change = qual && run_live && differs;
  assign ev_sat    = qual && run_live && !differs && at_ceiling;
  assign ev_flush  = flush && !arm && run_live;
  assign emit      = ev_change || ev_sat || ev_flush;
  assign load_one  = qual && (!run_live || emit);
  assign clear     = arm || (flush && !qual);
  assign bump      = qual && run_live && !emit;

  rle_change_det #(.VAL_W(VAL_W)) det_i (
    .clk(clk), .rst_n(rst_n), .capture(load_one), .probe(probe),
    .held_val(run_val), .differs(differs)
  );

  rle_run_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .load_one(load_one), .clear(clear), .bump(bump),
    .run_cnt(run_cnt), .run_live(run_live), .at_ceiling(at_ceiling)
  );

  rle_record_reg #(.CNT_W(CNT_W), .VAL_W(VAL_W)) rec_i (
    .clk(clk), .rst_n(rst_n), .emit(emit), .cnt(run_cnt), .val(run_val),
    .rec_valid(rec_valid), .rec_word(rec_word)
  );

  // R9
  empty_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_valid |-> rec_word == '0);

  // R9
  rec_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_word[REC_W-1:CNT_LSB] != '0) &&
                  (rec_word[REC_W-1:CNT_LSB] <= CNT_MAX));

  // R2
  change_emits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !arm && run_live && probe != run_val) |=> rec_valid);

  // R6
  flush_emits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !arm && run_live) |=> rec_valid);

  // R8
  arm_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !rec_valid);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_en && !flush && !arm) |=> !rec_valid && $stable(run_cnt));

endmodule

// File: tb/rle_sample_compressor_tb.sv
module rle_sample_compressor_tb_top;
  localparam int CW = 8;
  localparam int VW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          arm = 1'b0;
  logic          sample_en = 1'b0;
  logic          flush = 1'b0;
  logic [VW-1:0] probe = '0;
  logic          rec_valid;
  logic [CW+VW-1:0] rec_word;

  int checks = 0;
  int errors = 0;
  int bad_empty = 0;
  logic [CW+VW-1:0] obs_q[$];
  logic [CW+VW-1:0] exp_q[$];

  always #10 clk = ~clk;

  rle_sample_compressor #(.CNT_W(CW), .VAL_W(VW)) dut_i (
    .clk(clk), .rst_n(rst_n), .arm(arm), .sample_en(sample_en), .flush(flush),
    .probe(probe), .rec_valid(rec_valid), .rec_word(rec_word)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (rec_valid) obs_q.push_back(rec_word);
      else if (rec_word != '0) bad_empty++;
    end
  end

  function automatic logic [CW+VW-1:0] rec(input int c, input logic [VW-1:0] v);
    logic [CW-1:0] cc;
    cc = c[CW-1:0];
    return {cc, v};
  endfunction

  task automatic step(input logic en, input logic [VW-1:0] v, input logic fl, input logic ar);
    @(negedge clk);
    sample_en = en; probe = v; flush = fl; arm = ar;
  endtask

  task automatic settle();
    step(1'b0, '0, 1'b0, 1'b0);
    step(1'b0, '0, 1'b0, 1'b0);
    step(1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic compare(input string req);
    check({req, " record count"}, obs_q.size(), exp_q.size());
    foreach (exp_q[i]) begin
      if (i < obs_q.size()) check({req, " record"}, 32'(obs_q[i]), 32'(exp_q[i]));
    end
    obs_q.delete();
    exp_q.delete();
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 valid after reset", 32'(rec_valid), 0);
    check("R1 word after reset", 32'(rec_word), 0);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 300; i++) step(1'b1, 8'h5A, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b1, 1'b0);
    settle();
    exp_q.push_back(rec(254, 8'h5A));
    exp_q.push_back(rec(46, 8'h5A));
    compare("R3");
  endtask

  task automatic t_toggle();
    for (int i = 0; i < 10; i++) step(1'b1, (i % 2 == 0) ? 8'h0F : 8'hF0, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b1, 1'b0);
    settle();
    for (int i = 0; i < 10; i++) exp_q.push_back(rec(1, (i % 2 == 0) ? 8'h0F : 8'hF0));
    compare("R4");
  endtask

  task automatic t_mixed();
    for (int i = 0; i < 5; i++) step(1'b1, 8'hA1, 1'b0, 1'b0);
    step(1'b1, 8'hB2, 1'b0, 1'b0);
    for (int i = 0; i < 2; i++) step(1'b1, 8'hC3, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b1, 1'b0);
    settle();
    exp_q.push_back(rec(5, 8'hA1));
    exp_q.push_back(rec(1, 8'hB2));
    exp_q.push_back(rec(2, 8'hC3));
    compare("R2");
  endtask

  task automatic t_qualifier();
    for (int i = 0; i < 3; i++) step(1'b1, 8'h33, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b0, 8'h99, 1'b0, 1'b0);
    for (int i = 0; i < 2; i++) step(1'b1, 8'h33, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b1, 1'b0);
    settle();
    exp_q.push_back(rec(5, 8'h33));
    compare("R5");
  endtask

  task automatic t_arm();
    for (int i = 0; i < 4; i++) step(1'b1, 8'h44, 1'b0, 1'b0);
    step(1'b1, 8'h55, 1'b0, 1'b1);
    step(1'b0, 8'h00, 1'b0, 1'b0);
    @(negedge clk);
    check("R8 no record after arm", 32'(obs_q.size()), 0);
    step(1'b1, 8'h66, 1'b0, 1'b0);
    step(1'b1, 8'h66, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b1, 1'b0);
    settle();
    exp_q.push_back(rec(2, 8'h66));
    compare("R8");
  endtask

  task automatic t_flush_empty();
    step(1'b0, 8'h00, 1'b1, 1'b0);
    step(1'b0, 8'h00, 1'b1, 1'b0);
    settle();
    compare("R7");
  endtask

  task automatic t_flush_overlap();
    for (int i = 0; i < 3; i++) step(1'b1, 8'h77, 1'b0, 1'b0);
    step(1'b1, 8'h77, 1'b1, 1'b0);
    step(1'b1, 8'h77, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b1, 1'b0);
    settle();
    exp_q.push_back(rec(3, 8'h77));
    exp_q.push_back(rec(2, 8'h77));
    compare("R6");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mixed();
    t_saturate();
    t_toggle();
    t_qualifier();
    t_arm();
    t_flush_empty();
    t_flush_overlap();
    check("R9 zero word while idle", 32'(bad_empty), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule